// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block sits behind the address comparators of a processor's debug unit. When one or more breakpoint or watchpoint comparators report an address hit, the block decides whether that hit may actually raise a debug exception. It looks at each candidate slot's 32-bit control word and applies three tests. The first is the security-state selector against the current secure flag. The second is the privilege selectors against the current exception level. The third, when the slot is linked, is a context-ID comparison held in a second breakpoint slot. A global gate formed from the monitor-debug control word and the debug-exception enable overrides all of them.

A hit is presented as a one-cycle `hitValid` strobe. It comes with a vector of candidate slots and a flag that says whether the candidates are watchpoints or breakpoints. One cycle later the block returns a result strobe. The result carries a match flag, the index of the lowest qualifying slot and the fault status code that the exception logic should report. Address comparison and exception entry are done elsewhere.

Top module: `dbg_match_qual`

## Requirements
- R1: After reset all outputs are 0. `resValid` is 1 exactly in the cycle after a cycle with `hitValid` high, and `resMatch`, `resSlot` and `resFsr` are 0 whenever `resValid` is 0.
- R2: No match is reported unless bit 15 of `monDebugCtrl` is 1 and `debugExcEn` is 1.
- R3: The security selector sits in control bits [15:14]. Value 0 allows either state. Values 1 and 3 require `secureState`=0. Value 2 requires `secureState`=1.
- R4: At `curEl` 2 or 3, control bit 13 must be 1. At `curEl` 1, control bit 1 must be 1. At `curEl` 0, control bit 2 must be 1.
- R5: Only slots whose `hitCand` bit is 1 can match. When several candidates qualify, the lowest index is reported in `resSlot`.
- R6: When control bit 20 (linked) is 1, the linked number in bits [19:16] must be no greater than `debugId[27:24]`, and it must be at least `debugId[27:24]` minus `debugId[23:20]`. Otherwise the slot does not match.
- R7: The linked target breakpoint must have enable bit 0 set and its type field bits [23:20] equal to 3. Any other type gives no match.
- R8: A linked slot matches only if `contextId` equals the target's value word and `curEl` is 0 or 1.
- R9: On a match, `resFsr` is 0x222 when `extAddrMode` is 1 and 0x002 when it is 0.
- R10: When `hitIsWatch` is 1, the slot control words come from `wpCtrlFlat`; otherwise they come from `bpCtrlFlat`. Linked targets always come from the breakpoint bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitValid | input | 1 | Candidate hit strobe |
| hitIsWatch | input | 1 | Candidates are watchpoints (1) or breakpoints (0) |
| hitCand | input | NUM_SLOTS | Address-matched slots |
| curEl | input | 2 | Current exception level |
| secureState | input | 1 | Core is in secure state |
| monDebugCtrl | input | 32 | Monitor debug control word, bit 15 is the global enable |
| debugExcEn | input | 1 | Debug exceptions may be taken now |
| contextId | input | 32 | Current context identifier |
| extAddrMode | input | 1 | Long-descriptor fault status format selected |
| debugId | input | 32 | Debug ID word holding breakpoint and context comparator counts |
| bpCtrlFlat | input | NUM_BP*32 | Breakpoint control words, slot i at [i*32 +: 32] |
| bpValueFlat | input | NUM_BP*32 | Breakpoint value words, low 32 bits |
| wpCtrlFlat | input | NUM_WP*32 | Watchpoint control words |
| resValid | output | 1 | Result strobe |
| resMatch | output | 1 | Hit qualifies for a debug exception |
| resSlot | output | SLOT_W | Winning slot index |
| resFsr | output | 10 | Fault status code to report |

## Verification
Every result is due one clock edge after the edge that samples `hitValid`. The qualification path is purely combinational up to a single output register. The bench drives all inputs on the falling edge and holds the strobe for one cycle. It reads the outputs on the falling edge that follows the capturing rising edge, which is exactly where the registered result first appears. The no-stimulus case is read in the same way to confirm that no strobe appears without a hit.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
  localparam int CTRL_W = 32;
  localparam int LBN_W  = 4;
  localparam int FSR_W  = 10;

  // slot control word field positions
  localparam int EN_BIT     = 0;
  localparam int PAC_LO     = 1;
  localparam int HMC_BIT    = 13;
  localparam int SSC_LO     = 14;
  localparam int LBN_LO     = 16;
  localparam int LINKED_BIT = 20;
  localparam int TYPE_LO    = 20;

  // debug ID word fields
  localparam int BRPS_LO = 24;
  localparam int CTXC_LO = 20;

  localparam int GLOBAL_EN_BIT = 15;
  localparam logic [3:0] TYPE_CTXID = 4'd3;

  localparam logic [FSR_W-1:0] FSR_LONG  = 10'h222;
  localparam logic [FSR_W-1:0] FSR_SHORT = 10'h002;

  typedef struct packed {
    logic capture;
    logic permit;
  } qualStrobe_t;
endpackage

// File: rtl/dbgq_link_check.sv
module dbgq_link_check
  import dbgq_pkg::*;
#(
  parameter int NUM_BP = 16
) (
  input  logic [LBN_W-1:0]         lbn,
  input  logic [NUM_BP*CTRL_W-1:0] bpCtrlFlat,
  input  logic [NUM_BP*CTRL_W-1:0] bpValueFlat,
  input  logic [31:0]              debugId,
  input  logic [31:0]              contextId,
  input  logic [1:0]               curEl,
  output logic                     linkOk
);
  logic [LBN_W-1:0]  brpsField;
  logic [LBN_W-1:0]  ctxField;
  logic              inRange;
  logic              inBank;
  logic [CTRL_W-1:0] tgtCtrl;
  logic [CTRL_W-1:0] tgtValue;
  logic              unusedBits;

  assign brpsField = debugId[BRPS_LO +: LBN_W];
  assign ctxField  = debugId[CTXC_LO +: LBN_W];

  // lbn >= brps - ctx is written as lbn + ctx >= brps to stay unsigned
  assign inRange = ({1'b0, lbn} <= {1'b0, brpsField}) &&
                   (({1'b0, lbn} + {1'b0, ctxField}) >= {1'b0, brpsField});
  assign inBank  = (32'(lbn) < NUM_BP);

  always_comb begin
    tgtCtrl  = '0;
    tgtValue = '0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (lbn == LBN_W'(i)) begin
        tgtCtrl  = bpCtrlFlat[i*CTRL_W +: CTRL_W];
        tgtValue = bpValueFlat[i*CTRL_W +: CTRL_W];
      end
    end
  end

  assign linkOk = inRange && inBank &&
                  tgtCtrl[EN_BIT] &&
                  (tgtCtrl[TYPE_LO +: 4] == TYPE_CTXID) &&
                  (curEl <= 2'd1) &&
                  (contextId == tgtValue);

  assign unusedBits = ^{debugId[31:28], debugId[19:0], tgtCtrl[31:24], tgtCtrl[19:1]};
endmodule

// File: rtl/dbgq_slot_qual.sv
module dbgq_slot_qual
  import dbgq_pkg::*;
#(
  parameter int NUM_BP = 16
) (
  input  logic [CTRL_W-1:0]        slotCtrl,
  input  logic [NUM_BP*CTRL_W-1:0] bpCtrlFlat,
  input  logic [NUM_BP*CTRL_W-1:0] bpValueFlat,
  input  logic [31:0]              debugId,
  input  logic [31:0]              contextId,
  input  logic [1:0]               curEl,
  input  logic                     secureState,
  output logic                     qualOk
);
  logic [1:0]       pacField;
  logic             hmcField;
  logic [1:0]       sscField;
  logic [LBN_W-1:0] lbnField;
  logic             linkedField;
  logic             secOk;
  logic             elOk;
  logic             linkOk;
  logic             unusedBits;

  assign pacField    = slotCtrl[PAC_LO +: 2];
  assign hmcField    = slotCtrl[HMC_BIT];
  assign sscField    = slotCtrl[SSC_LO +: 2];
  assign lbnField    = slotCtrl[LBN_LO +: LBN_W];
  assign linkedField = slotCtrl[LINKED_BIT];

  always_comb begin
    unique case (sscField)
      2'd0:    secOk = 1'b1;
      2'd2:    secOk = secureState;
      default: secOk = !secureState;
    endcase
  end

  always_comb begin
    unique case (curEl)
      2'd0:    elOk = pacField[1];
      2'd1:    elOk = pacField[0];
      default: elOk = hmcField;
    endcase
  end

  dbgq_link_check #(.NUM_BP(NUM_BP)) linkUnit (
    .lbn        (lbnField),
    .bpCtrlFlat (bpCtrlFlat),
    .bpValueFlat(bpValueFlat),
    .debugId    (debugId),
    .contextId  (contextId),
    .curEl      (curEl),
    .linkOk     (linkOk)
  );

  assign qualOk = secOk && elOk && (!linkedField || linkOk);

  assign unusedBits = ^{slotCtrl[31:21], slotCtrl[12:3], slotCtrl[EN_BIT]};
endmodule

// File: rtl/dbgq_ctrl.sv
module dbgq_ctrl
  import dbgq_pkg::*;
(
  input  logic        hitValid,
  input  logic [31:0] monDebugCtrl,
  input  logic        debugExcEn,
  output qualStrobe_t strobe
);
  logic unusedBits;

  always_comb begin
    strobe.capture = hitValid;
    strobe.permit  = monDebugCtrl[GLOBAL_EN_BIT] && debugExcEn;
  end

  assign unusedBits = ^{monDebugCtrl[31:16], monDebugCtrl[14:0]};
endmodule

// File: rtl/dbgq_datapath.sv
module dbgq_datapath
  import dbgq_pkg::*;
#(
  parameter int NUM_BP    = 16,
  parameter int NUM_WP    = 16,
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qualStrobe_t              strobe,
  input  logic                     hitIsWatch,
  input  logic [NUM_SLOTS-1:0]     hitCand,
  input  logic [1:0]               curEl,
  input  logic                     secureState,
  input  logic [31:0]              contextId,
  input  logic                     extAddrMode,
  input  logic [31:0]              debugId,
  input  logic [NUM_BP*CTRL_W-1:0] bpCtrlFlat,
  input  logic [NUM_BP*CTRL_W-1:0] bpValueFlat,
  input  logic [NUM_WP*CTRL_W-1:0] wpCtrlFlat,
  output logic                     resValid,
  output logic                     resMatch,
  output logic [SLOT_W-1:0]        resSlot,
  output logic [FSR_W-1:0]         resFsr
);
  logic [NUM_SLOTS-1:0] slotOk;
  logic                 found;
  logic [SLOT_W-1:0]    pick;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CTRL_W-1:0] slotCtrl;

    if (s < NUM_BP && s < NUM_WP) begin : g_both
      assign slotCtrl = hitIsWatch ? wpCtrlFlat[s*CTRL_W +: CTRL_W]
                                   : bpCtrlFlat[s*CTRL_W +: CTRL_W];
    end else if (s < NUM_BP) begin : g_bp_only
      assign slotCtrl = hitIsWatch ? '0 : bpCtrlFlat[s*CTRL_W +: CTRL_W];
    end else begin : g_wp_only
      assign slotCtrl = hitIsWatch ? wpCtrlFlat[s*CTRL_W +: CTRL_W] : '0;
    end

    dbgq_slot_qual #(.NUM_BP(NUM_BP)) qual (
      .slotCtrl   (slotCtrl),
      .bpCtrlFlat (bpCtrlFlat),
      .bpValueFlat(bpValueFlat),
      .debugId    (debugId),
      .contextId  (contextId),
      .curEl      (curEl),
      .secureState(secureState),
      .qualOk     (slotOk[s])
    );
  end

  // descending scan so the lowest qualifying index is the last one written
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hitCand[s] && slotOk[s]) begin
        found = 1'b1;
        pick  = SLOT_W'(s);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resMatch <= 1'b0;
      resSlot  <= '0;
      resFsr   <= '0;
    end else begin
      resValid <= strobe.capture;
      if (strobe.capture && strobe.permit && found) begin
        resMatch <= 1'b1;
        resSlot  <= pick;
        resFsr   <= extAddrMode ? FSR_LONG : FSR_SHORT;
      end else begin
        resMatch <= 1'b0;
        resSlot  <= '0;
        resFsr   <= '0;
      end
    end
  end
endmodule

// File: rtl/dbg_match_qual.sv
module dbg_match_qual
  import dbgq_pkg::*;
#(
  parameter int NUM_BP = 16,
  parameter int NUM_WP = 16,
  localparam int NUM_SLOTS = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hitValid,
  input  logic                     hitIsWatch,
  input  logic [NUM_SLOTS-1:0]     hitCand,
  input  logic [1:0]               curEl,
  input  logic                     secureState,
  input  logic [31:0]              monDebugCtrl,
  input  logic                     debugExcEn,
  input  logic [31:0]              contextId,
  input  logic                     extAddrMode,
  input  logic [31:0]              debugId,
  input  logic [NUM_BP*32-1:0]     bpCtrlFlat,
  input  logic [NUM_BP*32-1:0]     bpValueFlat,
  input  logic [NUM_WP*32-1:0]     wpCtrlFlat,
  output logic                     resValid,
  output logic                     resMatch,
  output logic [SLOT_W-1:0]        resSlot,
  output logic [9:0]               resFsr
);
  qualStrobe_t strobe;

  dbgq_ctrl ctrl (
    .hitValid    (hitValid),
    .monDebugCtrl(monDebugCtrl),
    .debugExcEn  (debugExcEn),
    .strobe      (strobe)
  );

  dbgq_datapath #(
    .NUM_BP   (NUM_BP),
    .NUM_WP   (NUM_WP),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hitIsWatch (hitIsWatch),
    .hitCand    (hitCand),
    .curEl      (curEl),
    .secureState(secureState),
    .contextId  (contextId),
    .extAddrMode(extAddrMode),
    .debugId    (debugId),
    .bpCtrlFlat (bpCtrlFlat),
    .bpValueFlat(bpValueFlat),
    .wpCtrlFlat (wpCtrlFlat),
    .resValid   (resValid),
    .resMatch   (resMatch),
    .resSlot    (resSlot),
    .resFsr     (resFsr)
  );
endmodule

// File: rtl/dbg_match_qual_chk.sv
module dbg_match_qual_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hitValid,
  input logic [NUM_SLOTS-1:0] hitCand,
  input logic [31:0]          monDebugCtrl,
  input logic                 debugExcEn,
  input logic                 extAddrMode,
  input logic                 resValid,
  input logic                 resMatch,
  input logic [SLOT_W-1:0]    resSlot,
  input logic [9:0]           resFsr
);
  logic [NUM_SLOTS-1:0] candQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) candQ <= '0;
    else       candQ <= hitCand;
  end

  // R1
  result_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(hitValid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!resMatch && resSlot == '0 && resFsr == '0));

  // R2
  global_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !$past(monDebugCtrl[15] && debugExcEn)) |-> !resMatch);

  // R5
  winner_is_candidate_chk: assert property (@(posedge clk) disable iff (!rstN)
    resMatch |-> candQ[resSlot]);

  // R9
  fsr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    resMatch |-> (resFsr == ($past(extAddrMode) ? 10'h222 : 10'h002)));
endmodule

bind dbg_match_qual dbg_match_qual_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_W   (SLOT_W)
) chk (
  .clk         (clk),
  .rstN        (rstN),
  .hitValid    (hitValid),
  .hitCand     (hitCand),
  .monDebugCtrl(monDebugCtrl),
  .debugExcEn  (debugExcEn),
  .extAddrMode (extAddrMode),
  .resValid    (resValid),
  .resMatch    (resMatch),
  .resSlot     (resSlot),
  .resFsr      (resFsr)
);

// File: tb/dbg_match_qual_test.sv
module dbg_match_qual_test;
  localparam int NB = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hitValid = 1'b0;
  logic          hitIsWatch = 1'b0;
  logic [NB-1:0] hitCand = '0;
  logic [1:0]    curEl = 2'd1;
  logic          secureState = 1'b0;
  logic [31:0]   monDebugCtrl = 32'h8000;
  logic          debugExcEn = 1'b1;
  logic [31:0]   contextId = 32'h0;
  logic          extAddrMode = 1'b0;
  logic [31:0]   debugId = 32'h0F30_0000;
  logic [31:0]   bpCtrl [NB];
  logic [31:0]   bpValue[NB];
  logic [31:0]   wpCtrl [NB];
  logic [NB*32-1:0] bpCtrlFlat, bpValueFlat, wpCtrlFlat;
  logic          resValid, resMatch;
  logic [3:0]    resSlot;
  logic [9:0]    resFsr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      bpCtrlFlat[i*32 +: 32]  = bpCtrl[i];
      bpValueFlat[i*32 +: 32] = bpValue[i];
      wpCtrlFlat[i*32 +: 32]  = wpCtrl[i];
    end
  end

  dbg_match_qual uut (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitIsWatch(hitIsWatch),
    .hitCand(hitCand), .curEl(curEl), .secureState(secureState),
    .monDebugCtrl(monDebugCtrl), .debugExcEn(debugExcEn), .contextId(contextId),
    .extAddrMode(extAddrMode), .debugId(debugId), .bpCtrlFlat(bpCtrlFlat),
    .bpValueFlat(bpValueFlat), .wpCtrlFlat(wpCtrlFlat), .resValid(resValid),
    .resMatch(resMatch), .resSlot(resSlot), .resFsr(resFsr)
  );

  function automatic logic [31:0] mkCtrl(logic [1:0] pac, logic hmc, logic [1:0] ssc,
                                         logic [3:0] lbn, logic linked);
    return {11'b0, linked, lbn, ssc, hmc, 10'b0, pac, 1'b1};
  endfunction

  function automatic logic [31:0] mkTarget(logic en, logic [3:0] kind);
    return {8'b0, kind, 19'b0, en};
  endfunction

  task automatic clearEnv();
    for (int i = 0; i < NB; i++) begin
      bpCtrl[i] = '0; bpValue[i] = '0; wpCtrl[i] = '0;
    end
    hitIsWatch = 0; hitCand = '0; curEl = 2'd1; secureState = 0;
    monDebugCtrl = 32'h8000; debugExcEn = 1; contextId = 0;
    extAddrMode = 0; debugId = 32'h0F30_0000;
  endtask

  // strobe one hit, return on the falling edge where the result is visible
  task automatic fire();
    @(negedge clk);
    hitValid = 1;
    @(negedge clk);
    hitValid = 0;
  endtask

  task automatic expectRes(string req, logic m, logic [3:0] s, logic [9:0] f);
    logic [15:0] act, exp;
    act = {resValid, resMatch, resSlot, resFsr};
    exp = {1'b1, m, m ? s : 4'd0, m ? f : 10'd0};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: valid/match/slot/fsr actual=%b/%b/%0d/%h expected=%b/%b/%0d/%h",
               req, resValid, resMatch, resSlot, resFsr, exp[15], exp[14], exp[13:10], exp[9:0]);
    end
  endtask

  task automatic testReset();
    checks++;
    if ({resValid, resMatch, resSlot, resFsr} !== 16'h0) begin
      failures++;
      $display("FAIL R1 reset: actual=%h expected=0", {resValid, resMatch, resSlot, resFsr});
    end
  endtask

  task automatic testNoStrobe();
    clearEnv();
    bpCtrl[3] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    hitCand = 16'h0008;
    repeat (3) @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resMatch !== 1'b0) begin
      failures++;
      $display("FAIL R1 no strobe: actual=%b%b expected=00", resValid, resMatch);
    end
  endtask

  task automatic testBasicAndFsr();
    clearEnv();
    bpCtrl[3] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    hitCand = 16'h0008;
    fire(); expectRes("R9 short fsr", 1, 3, 10'h002);
    extAddrMode = 1;
    fire(); expectRes("R9 long fsr", 1, 3, 10'h222);
  endtask

  task automatic testGlobal();
    clearEnv();
    bpCtrl[3] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    hitCand = 16'h0008;
    monDebugCtrl = 32'hFFFF_7FFF;
    fire(); expectRes("R2 bit15 clear", 0, 0, 0);
    monDebugCtrl = 32'h8000; debugExcEn = 0;
    fire(); expectRes("R2 exc disabled", 0, 0, 0);
  endtask

  task automatic testSecurity();
    clearEnv();
    hitCand = 16'h0001;
    bpCtrl[0] = mkCtrl(2'b01, 0, 2'd2, 0, 0);
    fire(); expectRes("R3 ssc2 nonsecure", 0, 0, 0);
    secureState = 1;
    fire(); expectRes("R3 ssc2 secure", 1, 0, 10'h002);
    bpCtrl[0] = mkCtrl(2'b01, 0, 2'd1, 0, 0);
    fire(); expectRes("R3 ssc1 secure", 0, 0, 0);
    bpCtrl[0] = mkCtrl(2'b01, 0, 2'd3, 0, 0); secureState = 0;
    fire(); expectRes("R3 ssc3 nonsecure", 1, 0, 10'h002);
  endtask

  task automatic testPrivilege();
    clearEnv();
    hitCand = 16'h0010;
    curEl = 2'd0;
    bpCtrl[4] = mkCtrl(2'b01, 1, 2'd0, 0, 0);
    fire(); expectRes("R4 el0 pac01", 0, 0, 0);
    bpCtrl[4] = mkCtrl(2'b10, 0, 2'd0, 0, 0);
    fire(); expectRes("R4 el0 pac10", 1, 4, 10'h002);
    curEl = 2'd2; bpCtrl[4] = mkCtrl(2'b11, 0, 2'd0, 0, 0);
    fire(); expectRes("R4 el2 hmc0", 0, 0, 0);
    curEl = 2'd3; bpCtrl[4] = mkCtrl(2'b00, 1, 2'd0, 0, 0);
    fire(); expectRes("R4 el3 hmc1", 1, 4, 10'h002);
  endtask

  task automatic testPriority();
    clearEnv();
    bpCtrl[5] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    bpCtrl[9] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    bpCtrl[1] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    hitCand = 16'h0220;
    fire(); expectRes("R5 lowest wins", 1, 5, 10'h002);
    bpCtrl[5] = mkCtrl(2'b10, 0, 2'd0, 0, 0);
    fire(); expectRes("R5 next qualifying", 1, 9, 10'h002);
    hitCand = 16'h0000;
    fire(); expectRes("R5 no candidate", 0, 0, 0);
  endtask

  task automatic testBank();
    clearEnv();
    hitCand = 16'h0004;
    wpCtrl[2] = mkCtrl(2'b01, 0, 2'd0, 0, 0);
    bpCtrl[2] = mkCtrl(2'b10, 0, 2'd0, 0, 0);
    hitIsWatch = 1;
    fire(); expectRes("R10 watch bank", 1, 2, 10'h002);
    hitIsWatch = 0;
    fire(); expectRes("R10 break bank", 0, 0, 0);
  endtask

  task automatic testLinked();
    clearEnv();
    hitCand = 16'h0001;
    contextId = 32'hCAFE_0042;
    bpCtrl[13] = mkTarget(1, 4'd3); bpValue[13] = 32'hCAFE_0042;
    bpCtrl[11] = mkTarget(1, 4'd3); bpValue[11] = 32'hCAFE_0042;
    bpCtrl[0] = mkCtrl(2'b01, 1, 2'd0, 4'd13, 1);
    fire(); expectRes("R6 linked in range", 1, 0, 10'h002);
    bpCtrl[0] = mkCtrl(2'b01, 1, 2'd0, 4'd11, 1);
    fire(); expectRes("R6 below range", 0, 0, 0);
    debugId = 32'h0D30_0000;
    bpCtrl[14] = mkTarget(1, 4'd3); bpValue[14] = 32'hCAFE_0042;
    bpCtrl[0] = mkCtrl(2'b01, 1, 2'd0, 4'd14, 1);
    fire(); expectRes("R6 above count", 0, 0, 0);
    debugId = 32'h0F30_0000;
    bpCtrl[0] = mkCtrl(2'b01, 1, 2'd0, 4'd13, 1);
    bpCtrl[13] = mkTarget(1, 4'd5);
    fire(); expectRes("R7 wrong type", 0, 0, 0);
    bpCtrl[13] = mkTarget(0, 4'd3);
    fire(); expectRes("R7 target disabled", 0, 0, 0);
    bpCtrl[13] = mkTarget(1, 4'd3);
    contextId = 32'hCAFE_0043;
    fire(); expectRes("R8 context differs", 0, 0, 0);
    contextId = 32'hCAFE_0042; curEl = 2'd2;
    fire(); expectRes("R8 el2 linked", 0, 0, 0);
    curEl = 2'd1;
    fire(); expectRes("R8 el1 linked", 1, 0, 10'h002);
  endtask

  initial begin
    clearEnv();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testNoStrobe();
    testBasicAndFsr();
    testGlobal();
    testSecurity();
    testPrivilege();
    testPriority();
    testBank();
    testLinked();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule